// File: doc/BRIEF.md
# System Control Register Write Unit

This block holds the writable system control registers of a 32-bit processor core and applies the move-to-control-register writes that the pipeline issues. Each write names a register by a 5-bit number and a 3-bit select, and carries 32 bits of data. Every register merges the data through its own pair of masks. Bits in the keep mask hold their old value. Bits in the take mask load from the data. Bits in neither mask become zero. Every register value is driven out of the block so that the rest of the core can use it.

Besides the register state, the block derives four mode flags: user mode, error level, exception level and debug mode. It also produces three kinds of side effect. A one-cycle request tells the translation buffer to flush all of its entries when the address-space identifier changes. A sticky hardware-interrupt request is raised or dropped by writes to the status register. One-cycle load strobes, with a shared data word, go to an external timer for its counter and its comparator.

Each result appears after the first rising clock edge that samples the write. The reset input is asserted asynchronously and active low. Its release is synchronised inside the block.

Top module: `sysctl_wr_unit`

## Requirements
- R1: After reset, the registers hold the following values, with every other register zero. Status (12) is 0x00000004. Config0 (16) is 0x80000080. Debug (23) is 0x04000000. The error-level flag is 1. The user, exception-level and debug flags are 0. The interrupt request, the flush request and both load strobes are 0.
- R2: A write with a nonzero select, or a write to any register number outside {0,2,3,4,5,6,9,10,11,12,13,14,16,18,19,23,24,28,30,31}, changes no register and no flag, and produces no strobe or flush. The only selects that registers 16 and 28 accept are select 0.
- R3: A write to Index (0) keeps bit 31, loads bits 3:0 from the data, and clears bits 30:4.
- R4: The following registers load the data bits under their mask and keep their other bits:
  - EntryLo0 and EntryLo1 (2 and 3): 0x3FFFFFFF.
  - PageMask (5): 0x01FFE000.
  - Wired (6): 0x0000000F.
  - EntryHi (10): 0xFFFFE0FF.
  - WatchHi (19): 0x40FF0FF8.
  - TagLo (28): 0xFFFFFCF6.
  - Context (4) keeps bits 31:23 and loads bits 22:4.
- R5: A write to Status (12) stores the data ANDed with 0xFA78FF01.
- R6: Three registers keep the old bits under one mask, load the data bits under a second mask, and clear all other bits:
  - Cause (13): keep 0xB000F87C, load 0x00000300.
  - Config0 (16): keep 0x8017FF80, load 0x7E000001.
  - Debug (23): keep 0x8C03FC1F, load 0x13300120.
- R7: EPC (14), WatchLo (18), DEPC (24), ErrorEPC (30) and DESAVE (31) store all 32 data bits.
- R8: A write to Count (9) or Compare (11) raises that register's load strobe for exactly one cycle. The strobe data output takes the written word and holds it until the next such write.
- R9: A write to EntryHi whose bits 7:0 differ from the stored bits 7:0 raises the flush request for exactly one cycle. A write whose bits 7:0 are equal raises no flush.
- R10: A Status write sets the user flag from data bit 4, the error-level flag from bit 2 and the exception-level flag from bit 1. A Debug write sets the debug flag from data bit 30.
- R11: The interrupt request is set when a Status write meets all of these conditions:
  - Data bit 0 is 1 and the stored Status bit 0 is 0.
  - Data bits 1 and 2 are 0.
  - The debug flag is clear.
  - The data and the current Cause share a set bit in 15:8.
  Otherwise the request holds, except as R12 states.
- R12: A Status write with data bit 0 equal to 0 while the stored bit 0 is 1 clears the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_num | input | 5 | Register number |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| index_o | output | 32 | Index register |
| entrylo0_o | output | 32 | EntryLo0 register |
| entrylo1_o | output | 32 | EntryLo1 register |
| context_o | output | 32 | Context register |
| pagemask_o | output | 32 | PageMask register |
| wired_o | output | 32 | Wired register |
| entryhi_o | output | 32 | EntryHi register |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | EPC register |
| config0_o | output | 32 | Config0 register |
| watchlo_o | output | 32 | WatchLo register |
| watchhi_o | output | 32 | WatchHi register |
| debug_o | output | 32 | Debug register |
| depc_o | output | 32 | DEPC register |
| taglo_o | output | 32 | TagLo register |
| errorepc_o | output | 32 | ErrorEPC register |
| desave_o | output | 32 | DESAVE register |
| count_load | output | 1 | One-cycle strobe that loads the timer counter |
| compare_load | output | 1 | One-cycle strobe that loads the timer comparator |
| load_value | output | 32 | Data word for the timer load strobes |
| mode_user | output | 1 | User-mode flag |
| mode_errlvl | output | 1 | Error-level flag |
| mode_exclvl | output | 1 | Exception-level flag |
| mode_debug | output | 1 | Debug-mode flag |
| tlb_flush | output | 1 | One-cycle request to flush the whole translation buffer |
| hw_irq_req | output | 1 | Sticky hardware-interrupt request |

## Verification
Every register, flag, strobe and request is registered once, so each result of a write is due at the first rising edge that samples it. The bench drives each write just after a falling edge and compares every output at the next falling edge, half a cycle after the edge that is due to update it. It then holds the write port idle for one more edge and checks again, which shows that the flush request and the load strobes last exactly one cycle while the register state holds. The interrupt-request cases depend on state that earlier writes set up: the Cause software bits, the debug flag and the old interrupt-enable bit. They are built as directed sequences before the random phase.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DW    = 32;
  localparam int NUM_W = 5;
  localparam int SEL_W = 3;

  // storage slots first, strobe-only slots after, then "no target"
  typedef enum logic [4:0] {
    S_INDEX, S_ELO0, S_ELO1, S_CTX, S_PMASK, S_WIRED, S_EHI, S_STATUS,
    S_CAUSE, S_EPC, S_CFG0, S_WLO, S_WHI, S_DEBUG, S_DEPC, S_TAGLO,
    S_EEPC, S_DSAVE, S_COUNT, S_COMPARE, S_NONE
  } slot_e;

  localparam int NSTORE = 18;
  localparam int NSLOT  = 20;

  // status bit positions used by the side-effect logic
  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_UM  = 4;
  localparam int DB_DM  = 30;

  function automatic slot_e slot_of(input logic [NUM_W-1:0] num,
                                    input logic [SEL_W-1:0] sel);
    slot_e s;
    s = S_NONE;
    if (sel == '0) begin
      case (num)
        5'd0:    s = S_INDEX;
        5'd2:    s = S_ELO0;
        5'd3:    s = S_ELO1;
        5'd4:    s = S_CTX;
        5'd5:    s = S_PMASK;
        5'd6:    s = S_WIRED;
        5'd9:    s = S_COUNT;
        5'd10:   s = S_EHI;
        5'd11:   s = S_COMPARE;
        5'd12:   s = S_STATUS;
        5'd13:   s = S_CAUSE;
        5'd14:   s = S_EPC;
        5'd16:   s = S_CFG0;
        5'd18:   s = S_WLO;
        5'd19:   s = S_WHI;
        5'd23:   s = S_DEBUG;
        5'd24:   s = S_DEPC;
        5'd28:   s = S_TAGLO;
        5'd30:   s = S_EEPC;
        5'd31:   s = S_DSAVE;
        default: s = S_NONE;
      endcase
    end
    return s;
  endfunction

  function automatic logic [DW-1:0] take_mask(input slot_e s);
    case (s)
      S_INDEX:        return 32'h0000_000F;
      S_ELO0, S_ELO1: return 32'h3FFF_FFFF;
      S_CTX:          return 32'h007F_FFF0;
      S_PMASK:        return 32'h01FF_E000;
      S_WIRED:        return 32'h0000_000F;
      S_EHI:          return 32'hFFFF_E0FF;
      S_STATUS:       return 32'hFA78_FF01;
      S_CAUSE:        return 32'h0000_0300;
      S_CFG0:         return 32'h7E00_0001;
      S_WHI:          return 32'h40FF_0FF8;
      S_DEBUG:        return 32'h1330_0120;
      S_TAGLO:        return 32'hFFFF_FCF6;
      default:        return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] keep_mask(input slot_e s);
    case (s)
      S_INDEX:  return 32'h8000_0000;
      S_CTX:    return 32'hFF80_0000;
      S_CAUSE:  return 32'hB000_F87C;
      S_CFG0:   return 32'h8017_FF80;
      S_DEBUG:  return 32'h8C03_FC1F;
      S_ELO0, S_ELO1, S_PMASK, S_WIRED, S_EHI, S_WHI, S_TAGLO:
                return ~take_mask(s);
      default:  return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [DW-1:0] reset_val(input slot_e s);
    case (s)
      S_STATUS: return 32'h0000_0004;
      S_CFG0:   return 32'h8000_0080;
      S_DEBUG:  return 32'h0400_0000;
      default:  return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NUM_W-1:0] wr_num,
  input  logic [SEL_W-1:0] wr_sel,
  output logic [NSLOT-1:0] hit
);

  slot_e slot;

  always_comb begin
    slot = slot_of(wr_num, wr_sel);
    hit  = '0;
    if (wr_en && (slot != S_NONE)) hit[slot] = 1'b1;
  end

  // R2: a nonzero select never reaches any register
  p_sel_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel != '0) |-> (hit == '0));

  p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSTORE-1:0]          hit,
  input  logic [DW-1:0]              wdata,
  output logic [NSTORE-1:0][DW-1:0]  q
);

  for (genvar i = 0; i < NSTORE; i++) begin : g_reg
    localparam slot_e          SL   = slot_e'(i);
    localparam logic [DW-1:0]  KEEP = keep_mask(SL);
    localparam logic [DW-1:0]  TAKE = take_mask(SL);
    localparam logic [DW-1:0]  RSTV = reset_val(SL);

    logic [DW-1:0] r_q;
    logic [DW-1:0] r_d;
    logic          r_en;

    always_comb begin
      r_en = hit[i];
      r_d  = (r_q & KEEP) | (wdata & TAKE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    r_q <= RSTV;
      else if (r_en) r_q <= r_d;
    end

    assign q[i] = r_q;
  end

  // R2: no write target means the whole bank holds
  p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> $stable(q));

  // R3: index middle bits end up clear after a write
  p_index_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit[S_INDEX] |=> (q[S_INDEX][30:4] == '0));

  // R5: status never holds bits outside its writable set after a write
  p_status_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit[S_STATUS] |=> ((q[S_STATUS] & ~32'hFA78_FF01) == '0));

endmodule

// File: rtl/sysctl_side.sv
module sysctl_side
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_ehi,
  input  logic          hit_status,
  input  logic          hit_debug,
  input  logic          hit_count,
  input  logic          hit_compare,
  input  logic [DW-1:0] wdata,
  input  logic [7:0]    asid_old,
  input  logic          ie_old,
  input  logic [7:0]    cause_ip,
  output logic          mode_user,
  output logic          mode_errlvl,
  output logic          mode_exclvl,
  output logic          mode_debug,
  output logic          tlb_flush,
  output logic          hw_irq_req,
  output logic          count_load,
  output logic          compare_load,
  output logic [DW-1:0] load_value
);

  logic          um_d, erl_d, exl_d, dm_d, irq_d, flush_d;
  logic          cl_d, ml_d;
  logic [DW-1:0] lv_d;
  logic          lv_en, raise, drop;

  always_comb begin
    um_d  = mode_user;
    erl_d = mode_errlvl;
    exl_d = mode_exclvl;
    dm_d  = mode_debug;
    if (hit_status) begin
      um_d  = wdata[ST_UM];
      erl_d = wdata[ST_ERL];
      exl_d = wdata[ST_EXL];
    end
    if (hit_debug) dm_d = wdata[DB_DM];

    raise = hit_status && wdata[ST_IE] && !ie_old &&
            !wdata[ST_EXL] && !wdata[ST_ERL] && !mode_debug &&
            ((wdata[15:8] & cause_ip) != 8'h00);
    drop  = hit_status && !wdata[ST_IE] && ie_old;
    irq_d = hw_irq_req;
    if (raise)     irq_d = 1'b1;
    else if (drop) irq_d = 1'b0;

    flush_d = hit_ehi && (wdata[7:0] != asid_old);
    cl_d    = hit_count;
    ml_d    = hit_compare;
    lv_en   = hit_count || hit_compare;
    lv_d    = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_user    <= 1'b0;
      mode_errlvl  <= 1'b1;
      mode_exclvl  <= 1'b0;
      mode_debug   <= 1'b0;
      hw_irq_req   <= 1'b0;
      tlb_flush    <= 1'b0;
      count_load   <= 1'b0;
      compare_load <= 1'b0;
    end else begin
      mode_user    <= um_d;
      mode_errlvl  <= erl_d;
      mode_exclvl  <= exl_d;
      mode_debug   <= dm_d;
      hw_irq_req   <= irq_d;
      tlb_flush    <= flush_d;
      count_load   <= cl_d;
      compare_load <= ml_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     load_value <= '0;
    else if (lv_en) load_value <= lv_d;
  end

  // R8: a strobe only follows a write to its own register
  p_count_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count_load |-> $past(hit_count));
  p_cmp_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    compare_load |-> $past(hit_compare));

  // R9: flush only after an identifier-changing EntryHi write
  p_flush_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> $past(hit_ehi && (wdata[7:0] != asid_old)));

  // R10: debug flag moves only on a debug write
  p_dm_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_debug |=> $stable(mode_debug));

  // R11: request rises only on a status write setting IE
  p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hw_irq_req) |-> $past(hit_status && wdata[ST_IE]));

  // R12: request falls only on a status write clearing IE
  p_irq_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hw_irq_req) |-> $past(hit_status && !wdata[ST_IE]));

endmodule

// File: rtl/sysctl_wr_unit.sv
module sysctl_wr_unit
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [4:0]    wr_num,
  input  logic [2:0]    wr_sel,
  input  logic [31:0]   wr_data,
  output logic [31:0]   index_o,
  output logic [31:0]   entrylo0_o,
  output logic [31:0]   entrylo1_o,
  output logic [31:0]   context_o,
  output logic [31:0]   pagemask_o,
  output logic [31:0]   wired_o,
  output logic [31:0]   entryhi_o,
  output logic [31:0]   status_o,
  output logic [31:0]   cause_o,
  output logic [31:0]   epc_o,
  output logic [31:0]   config0_o,
  output logic [31:0]   watchlo_o,
  output logic [31:0]   watchhi_o,
  output logic [31:0]   debug_o,
  output logic [31:0]   depc_o,
  output logic [31:0]   taglo_o,
  output logic [31:0]   errorepc_o,
  output logic [31:0]   desave_o,
  output logic          count_load,
  output logic          compare_load,
  output logic [31:0]   load_value,
  output logic          mode_user,
  output logic          mode_errlvl,
  output logic          mode_exclvl,
  output logic          mode_debug,
  output logic          tlb_flush,
  output logic          hw_irq_req
);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic [NSLOT-1:0]          hit;
  logic [NSTORE-1:0][DW-1:0] q;

  sysctl_decode u_decode (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_en  (wr_en),
    .wr_num (wr_num),
    .wr_sel (wr_sel),
    .hit    (hit)
  );

  sysctl_regbank u_bank (
    .clk   (clk),
    .rst_n (rst_core_n),
    .hit   (hit[NSTORE-1:0]),
    .wdata (wr_data),
    .q     (q)
  );

  sysctl_side u_side (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .hit_ehi      (hit[S_EHI]),
    .hit_status   (hit[S_STATUS]),
    .hit_debug    (hit[S_DEBUG]),
    .hit_count    (hit[S_COUNT]),
    .hit_compare  (hit[S_COMPARE]),
    .wdata        (wr_data),
    .asid_old     (q[S_EHI][7:0]),
    .ie_old       (q[S_STATUS][ST_IE]),
    .cause_ip     (q[S_CAUSE][15:8]),
    .mode_user    (mode_user),
    .mode_errlvl  (mode_errlvl),
    .mode_exclvl  (mode_exclvl),
    .mode_debug   (mode_debug),
    .tlb_flush    (tlb_flush),
    .hw_irq_req   (hw_irq_req),
    .count_load   (count_load),
    .compare_load (compare_load),
    .load_value   (load_value)
  );

  assign index_o    = q[S_INDEX];
  assign entrylo0_o = q[S_ELO0];
  assign entrylo1_o = q[S_ELO1];
  assign context_o  = q[S_CTX];
  assign pagemask_o = q[S_PMASK];
  assign wired_o    = q[S_WIRED];
  assign entryhi_o  = q[S_EHI];
  assign status_o   = q[S_STATUS];
  assign cause_o    = q[S_CAUSE];
  assign epc_o      = q[S_EPC];
  assign config0_o  = q[S_CFG0];
  assign watchlo_o  = q[S_WLO];
  assign watchhi_o  = q[S_WHI];
  assign debug_o    = q[S_DEBUG];
  assign depc_o     = q[S_DEPC];
  assign taglo_o    = q[S_TAGLO];
  assign errorepc_o = q[S_EEPC];
  assign desave_o   = q[S_DSAVE];

  // R8: the two timer strobes never fire together
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(count_load && compare_load));

endmodule

// File: tb/sysctl_wr_unit_test.sv
`timescale 1ns/1ps
module sysctl_wr_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_num;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic [31:0] index_o, entrylo0_o, entrylo1_o, context_o, pagemask_o, wired_o;
  logic [31:0] entryhi_o, status_o, cause_o, epc_o, config0_o, watchlo_o;
  logic [31:0] watchhi_o, debug_o, depc_o, taglo_o, errorepc_o, desave_o;
  logic        count_load, compare_load;
  logic [31:0] load_value;
  logic        mode_user, mode_errlvl, mode_exclvl, mode_debug;
  logic        tlb_flush, hw_irq_req;

  sysctl_wr_unit uut (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference state, indexed by register number
  logic [31:0] m [32];
  logic e_um, e_erl, e_exl, e_dm, e_irq, e_flush, e_cl, e_ml;
  logic [31:0] e_lv;

  localparam int NV = 18;
  localparam int VALID [NV] = '{0,2,3,4,5,6,10,12,13,14,16,18,19,23,24,28,30,31};

  function automatic logic [31:0] got(input int n);
    case (n)
      0:  return index_o;     2:  return entrylo0_o;  3:  return entrylo1_o;
      4:  return context_o;   5:  return pagemask_o;  6:  return wired_o;
      10: return entryhi_o;   12: return status_o;    13: return cause_o;
      14: return epc_o;       16: return config0_o;   18: return watchlo_o;
      19: return watchhi_o;   23: return debug_o;     24: return depc_o;
      28: return taglo_o;     30: return errorepc_o;  31: return desave_o;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input int n);
    case (n)
      0:                  return "R3";
      12:                 return "R5";
      13, 16, 23:         return "R6";
      14, 18, 24, 30, 31: return "R7";
      default:            return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input string why,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s [%s]: actual %h expected %h", req, what, why, act, exp);
    end
  endtask

  task automatic check_all(input string why, input string rq = "");
    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = (rq != "") ? rq : req_of(VALID[k]);
      chk(tag, $sformatf("reg%0d", VALID[k]), why, got(VALID[k]), m[VALID[k]]);
    end
    chk((rq != "") ? rq : "R10", "flag_um",  why, {31'b0, mode_user},   {31'b0, e_um});
    chk((rq != "") ? rq : "R10", "flag_erl", why, {31'b0, mode_errlvl}, {31'b0, e_erl});
    chk((rq != "") ? rq : "R10", "flag_exl", why, {31'b0, mode_exclvl}, {31'b0, e_exl});
    chk((rq != "") ? rq : "R10", "flag_dm",  why, {31'b0, mode_debug},  {31'b0, e_dm});
    chk((rq != "") ? rq : "R11", "irq",      why, {31'b0, hw_irq_req},  {31'b0, e_irq});
    chk((rq != "") ? rq : "R9",  "flush",    why, {31'b0, tlb_flush},   {31'b0, e_flush});
    chk((rq != "") ? rq : "R8",  "cnt_ld",   why, {31'b0, count_load},  {31'b0, e_cl});
    chk((rq != "") ? rq : "R8",  "cmp_ld",   why, {31'b0, compare_load},{31'b0, e_ml});
    chk((rq != "") ? rq : "R8",  "ld_val",   why, load_value, e_lv);
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [31:0] keep, input logic [31:0] take);
    return (old & keep) | (d & take);
  endfunction

  task automatic model_write(input int n, input int s, input logic [31:0] d);
    logic raise, drop;
    e_flush = 1'b0; e_cl = 1'b0; e_ml = 1'b0;
    if (s != 0) return;                       // R2
    case (n)
      0:  m[0]  = merge(m[0], d, 32'h8000_0000, 32'h0000_000F);
      2, 3: m[n] = merge(m[n], d, ~32'h3FFF_FFFF, 32'h3FFF_FFFF);
      4:  m[4]  = merge(m[4], d, 32'hFF80_0000, 32'h007F_FFF0);
      5:  m[5]  = merge(m[5], d, ~32'h01FF_E000, 32'h01FF_E000);
      6:  m[6]  = merge(m[6], d, ~32'h0000_000F, 32'h0000_000F);
      9:  begin e_cl = 1'b1; e_lv = d; end
      10: begin
            e_flush = (m[10][7:0] != d[7:0]);
            m[10] = merge(m[10], d, ~32'hFFFF_E0FF, 32'hFFFF_E0FF);
          end
      11: begin e_ml = 1'b1; e_lv = d; end
      12: begin
            raise = d[0] && !m[12][0] && !d[1] && !d[2] && !e_dm &&
                    ((d & m[13] & 32'h0000_FF00) != 0);
            drop  = !d[0] && m[12][0];
            if (raise) e_irq = 1'b1;
            else if (drop) e_irq = 1'b0;
            e_um = d[4]; e_erl = d[2]; e_exl = d[1];
            m[12] = d & 32'hFA78_FF01;
          end
      13: m[13] = merge(m[13], d, 32'hB000_F87C, 32'h0000_0300);
      14, 18, 24, 30, 31: m[n] = d;
      16: m[16] = merge(m[16], d, 32'h8017_FF80, 32'h7E00_0001);
      19: m[19] = merge(m[19], d, ~32'h40FF_0FF8, 32'h40FF_0FF8);
      23: begin e_dm = d[30]; m[23] = merge(m[23], d, 32'h8C03_FC1F, 32'h1330_0120); end
      28: m[28] = merge(m[28], d, ~32'hFFFF_FCF6, 32'hFFFF_FCF6);
      default: ;
    endcase
  endtask

  task automatic wr(input int n, input int s, input logic [31:0] d,
                    input string why, input string rq = "");
    @(negedge clk);
    wr_en = 1'b1; wr_num = n[4:0]; wr_sel = s[2:0]; wr_data = d;
    model_write(n, s, d);
    @(negedge clk);
    wr_en = 1'b0;
    check_all(why, rq);
  endtask

  task automatic idle_check(input string why, input string rq = "");
    e_flush = 1'b0; e_cl = 1'b0; e_ml = 1'b0;
    @(negedge clk);
    check_all(why, rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20061206));
    for (int k = 0; k < 32; k++) m[k] = 32'h0;
    m[12] = 32'h0000_0004; m[16] = 32'h8000_0080; m[23] = 32'h0400_0000;
    e_um = 0; e_erl = 1; e_exl = 0; e_dm = 0; e_irq = 0;
    e_flush = 0; e_cl = 0; e_ml = 0; e_lv = 32'h0;
    wr_en = 0; wr_num = 0; wr_sel = 0; wr_data = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("after reset", "R1");

    // R3 index
    wr(0, 0, 32'hFFFF_FFFF, "index all ones", "R3");
    // R4 masked registers
    wr(2, 0, 32'hFFFF_FFFF, "entrylo0 ones", "R4");
    wr(4, 0, 32'hFFFF_FFFF, "context ones", "R4");
    wr(28, 0, 32'hFFFF_FFFF, "taglo ones", "R4");
    // R6 merges
    wr(16, 0, 32'hFFFF_FFFF, "config0 ones", "R6");
    wr(16, 0, 32'h0000_0000, "config0 zeros keep", "R6");
    wr(23, 0, 32'h0000_0000, "debug zeros keep", "R6");
    // R7 full words
    wr(30, 0, 32'hDEAD_BEEF, "errorepc word", "R7");
    // R2 ignored writes
    wr(1, 0, 32'hFFFF_FFFF, "unlisted reg1", "R2");
    wr(16, 1, 32'h0000_0000, "config sel1", "R2");
    wr(28, 3, 32'h0000_0000, "taglo sel3", "R2");
    wr(12, 2, 32'h0000_0301, "status sel2", "R2");
    wr(9, 5, 32'h1234_5678, "count sel5", "R2");
    // R8 strobes
    wr(9, 0, 32'hCAFE_0001, "count load", "R8");
    idle_check("count strobe drops", "R8");
    wr(11, 0, 32'hCAFE_0002, "compare load", "R8");
    idle_check("compare strobe drops", "R8");
    // R9 flush
    wr(10, 0, 32'h0000_2012, "ehi first", "R9");
    idle_check("flush drops", "R9");
    wr(10, 0, 32'hFFFF_0012, "ehi same asid", "R9");
    wr(10, 0, 32'h0000_0013, "ehi new asid", "R9");
    // R10 / R11 / R12 interrupt sequence
    wr(13, 0, 32'h0000_0300, "cause soft bits", "R6");
    wr(12, 0, 32'h0000_0116, "status flags", "R10");
    wr(12, 0, 32'h0000_0000, "status clear", "R10");
    wr(12, 0, 32'h0000_0101, "irq raise", "R11");
    wr(12, 0, 32'h0000_0100, "irq drop", "R12");
    wr(12, 0, 32'h0000_0105, "raise blocked by erl", "R11");
    wr(12, 0, 32'h0000_0000, "ie off", "R12");
    wr(12, 0, 32'h0000_0401, "raise no shared bit", "R11");
    wr(12, 0, 32'h0000_0000, "ie off again", "R12");
    wr(23, 0, 32'h4000_0000, "debug flag on", "R10");
    wr(12, 0, 32'h0000_0201, "raise blocked by dm", "R11");
    wr(23, 0, 32'h0000_0000, "debug flag off", "R10");
    wr(12, 0, 32'h0000_0200, "ie off dm", "R12");
    wr(12, 0, 32'h0000_0203, "raise blocked by exl", "R11");

    // mixed random phase
    for (int it = 0; it < 3000; it++) begin
      int n, s;
      logic [31:0] d;
      n = $urandom_range(0, 31);
      s = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      d = $urandom;
      if ($urandom_range(0, 3) == 0) begin
        n = 12; s = 0; d = d & 32'h0000_FF17;
      end
      wr(n, s, d, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule